// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block is a hardware address translator for a 39-bit virtual address space with 4 KB pages. It takes one translation request at a time: the virtual address, the kind of access (load, store or instruction fetch) and whether the requester runs in user mode. It also takes the page number of the top-level table. It then walks a three-level radix tree of page tables held in memory. Each level costs one 64-bit read, issued on a simple request/response port with at most one read in flight.

Each table fills one 4 KB page and holds 512 entries of 8 bytes. Each level therefore uses 9 bits of the virtual page number: bits 38:30 at the top level, 29:21 at the middle and 20:12 at the bottom. An entry that grants any of read, write or execute is a leaf. At the middle level a leaf maps a 2 MB page and at the top level a 1 GB page; in both cases the walk ends at that leaf. The walker finishes with a one-cycle completion pulse that carries either a physical address or a fault flag.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req_valid`, `done`, `done_fault` and `done_paddr` are 0.
- R2: Entries use this layout: valid in bit 0, read in bit 1, write in bit 2, execute in bit 3, user in bit 4, page number in bits 53:10. The first read goes to `root_ppn`*4096 + index*8. Each later read goes to the previous entry's page number *4096 + index*8. At most one read is outstanding, at most three reads are made per walk, and `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready` is seen.
- R3: A leaf at the bottom level whose permissions allow the access completes with `done_paddr` = {leaf page number, vaddr[11:0]}, after exactly three reads.
- R4: Reaching an entry with bit 0 clear ends the walk with a fault, and no further read is issued.
- R5: An entry with the write bit set and the read bit clear faults.
- R6: An entry with valid set and read, write and execute all clear is a pointer to the next table. Finding such an entry at the bottom level faults.
- R7: A leaf at the middle level translates to {page number[43:9], vaddr[20:12], vaddr[11:0]} after two reads. A leaf at the top level translates to {page number[43:18], vaddr[29:12], vaddr[11:0]} after one read.
- R8: A middle-level leaf with page number bits 8:0 not all zero, or a top-level leaf with bits 17:0 not all zero, faults.
- R9: `req_acc` selects the right needed at the leaf: 0 is a load and needs read, 1 is a store and needs write, 2 is a fetch and needs execute. The value 3 always faults.
- R10: When `req_user` is 1 the leaf must have the user bit set, otherwise the walk faults. When `req_user` is 0 the user bit is ignored.
- R11: `done` is high for exactly one cycle per walk. A fault shows `done_fault`=1 with `done_paddr`=0. A request is taken only while `req_ready` is 1, and inputs presented while a walk is in progress do not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and taking a request |
| req_vaddr | input | 39 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | Requester runs in user mode |
| root_ppn | input | 44 | Page number of the top-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Returned entry |
| done | output | 1 | Walk finished (one-cycle pulse) |
| done_fault | output | 1 | Walk ended in a page fault |
| done_paddr | output | 56 | Translated physical address, 0 on fault |

## Verification
Two things can come due in the same cycle. One is the completion of a walk. The other is a new request, or a changed virtual address, arriving while that walk is still running. The bench keeps `req_valid` high with a different address for the whole walk and drops it in the cycle `done` is seen. It then checks that the reported address belongs to the first request and that `done` falls back low one cycle later. A second pairing is a stalled read port while the walker is holding a request. Here the bench withholds `mem_req_ready` for several cycles and judges the final address and the read count.

// File: rtl/ptw_pkg.sv
// Package: shared types and entry field positions for the page table walker.
// Assumes entries carry flags in the low bits and the page number from bit 10.
package ptw_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_CHECK,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    localparam int BIT_V   = 0;
    localparam int BIT_R   = 1;
    localparam int BIT_W   = 2;
    localparam int BIT_X   = 3;
    localparam int BIT_U   = 4;
    localparam int PPN_LSB = 10;

endpackage

// File: rtl/ptw_pte_decode.sv
// Entry decoder: splits a fetched table entry into flags and page number and
// classifies it as pointer, leaf or malformed. Pure combinational.
module ptw_pte_decode
    import ptw_pkg::*;
#(
    parameter int PTE_W = 64,
    parameter int PPN_W = 44
) (
    input  logic [PTE_W-1:0] pte,
    output logic             f_v,
    output logic             f_r,
    output logic             f_w,
    output logic             f_x,
    output logic             f_u,
    output logic [PPN_W-1:0] ppn,
    output logic             is_ptr,
    output logic             is_leaf,
    output logic             bad_enc
);

    logic unused_bits;

    // Field extraction.
    assign f_v = pte[BIT_V];
    assign f_r = pte[BIT_R];
    assign f_w = pte[BIT_W];
    assign f_x = pte[BIT_X];
    assign f_u = pte[BIT_U];
    assign ppn = pte[PPN_LSB +: PPN_W];

    // Classification: no rights means pointer, any right means leaf.
    assign is_ptr  = f_v && !f_r && !f_w && !f_x;
    assign is_leaf = f_v && (f_r || f_w || f_x);
    assign bad_enc = f_w && !f_r;

    assign unused_bits = ^{pte[PTE_W-1:PPN_LSB+PPN_W], pte[PPN_LSB-1:BIT_U+1]};

endmodule

// File: rtl/ptw_perm_check.sv
// Permission checker: decides whether a leaf grants the requested access.
// Assumes supervisor requests ignore the user flag.
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic [1:0] acc,
    input  logic       user,
    input  logic       f_r,
    input  logic       f_w,
    input  logic       f_x,
    input  logic       f_u,
    output logic       deny
);

    logic right_ok;

    // Right needed by the access kind.
    always_comb begin
        case (acc_kind_t'(acc))
            ACC_LOAD:  right_ok = f_r;
            ACC_STORE: right_ok = f_w;
            ACC_FETCH: right_ok = f_x;
            default:   right_ok = 1'b0;
        endcase
    end

    // Combine with the mode check.
    assign deny = !right_ok || (user && !f_u);

endmodule

// File: rtl/ptw_addr_gen.sv
// Address generator: forms the byte address of the entry to read at the
// current level, and the final physical address of a leaf, including the
// huge-page case where low virtual index bits replace page number bits.
module ptw_addr_gen #(
    parameter int LEVELS = 3,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int PPN_W  = 44,
    parameter int PTE_W  = 64
) (
    input  logic [LEVELS*IDX_W+OFF_W-1:0] va,
    input  logic [$clog2(LEVELS)-1:0]     level,
    input  logic [PPN_W-1:0]              tbl_ppn,
    input  logic [PPN_W-1:0]              leaf_ppn,
    output logic [PPN_W+OFF_W-1:0]        rd_addr,
    output logic [PPN_W+OFF_W-1:0]        leaf_pa,
    output logic                          misalign
);

    localparam int LVL_W     = $clog2(LEVELS);
    localparam int ENT_SHIFT = $clog2(PTE_W/8);
    localparam int PA_W      = PPN_W + OFF_W;
    localparam int HUGE_BITS = (LEVELS-1) * IDX_W;

    logic [IDX_W-1:0] idx;
    logic [PPN_W-1:0] low_mask;
    logic [PPN_W-1:0] pa_ppn;

    // Select the virtual index field of the current level.
    always_comb begin
        idx = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (level == LVL_W'(l)) idx = va[OFF_W + l*IDX_W +: IDX_W];
        end
    end

    // Entry address within the current table.
    assign rd_addr = {tbl_ppn, {OFF_W{1'b0}}} | PA_W'({idx, {ENT_SHIFT{1'b0}}});

    // Per page-number bit: below level*IDX_W it comes from the virtual address.
    for (genvar i = 0; i < PPN_W; i++) begin : g_bit
        if (i < HUGE_BITS) begin : g_low
            assign low_mask[i] = (32'(level) * IDX_W) > i;
            assign pa_ppn[i]   = low_mask[i] ? va[OFF_W+i] : leaf_ppn[i];
        end else begin : g_high
            assign low_mask[i] = 1'b0;
            assign pa_ppn[i]   = leaf_ppn[i];
        end
    end

    assign misalign = |(leaf_ppn & low_mask);
    assign leaf_pa  = {pa_ppn, va[OFF_W-1:0]};

endmodule

// File: rtl/ptw_walker.sv
// Page table walker top: a state machine that reads one entry per level,
// descends through pointers, stops at the first leaf, and reports either a
// physical address or a fault with a one-cycle done pulse. Assumes the
// memory port returns exactly one response per accepted read.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int LEVELS = 3,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int PPN_W  = 44,
    parameter int PTE_W  = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [LEVELS*IDX_W+OFF_W-1:0] req_vaddr,
    input  logic [1:0]                    req_acc,
    input  logic                          req_user,
    input  logic [PPN_W-1:0]              root_ppn,
    output logic                          mem_req_valid,
    input  logic                          mem_req_ready,
    output logic [PPN_W+OFF_W-1:0]        mem_req_addr,
    input  logic                          mem_rsp_valid,
    input  logic [PTE_W-1:0]              mem_rsp_data,
    output logic                          done,
    output logic                          done_fault,
    output logic [PPN_W+OFF_W-1:0]        done_paddr
);

    localparam int VA_W  = LEVELS*IDX_W + OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;
    localparam int LVL_W = $clog2(LEVELS);

    walk_state_t      state_q;
    logic [VA_W-1:0]  va_q;
    logic [1:0]       acc_q;
    logic             user_q;
    logic [PPN_W-1:0] ptr_q;
    logic [LVL_W-1:0] lvl_q;
    logic [PTE_W-1:0] pte_q;
    logic [PA_W-1:0]  pa_q;

    logic             f_v, f_r, f_w, f_x, f_u;
    logic [PPN_W-1:0] d_ppn;
    logic             is_ptr, is_leaf, bad_enc;
    logic             deny, misalign;
    logic [PA_W-1:0]  rd_addr, leaf_pa;
    logic             chk_fault;

    ptw_pte_decode #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_dec (
        .pte     (pte_q),
        .f_v     (f_v),
        .f_r     (f_r),
        .f_w     (f_w),
        .f_x     (f_x),
        .f_u     (f_u),
        .ppn     (d_ppn),
        .is_ptr  (is_ptr),
        .is_leaf (is_leaf),
        .bad_enc (bad_enc)
    );

    ptw_perm_check u_perm (
        .acc  (acc_q),
        .user (user_q),
        .f_r  (f_r),
        .f_w  (f_w),
        .f_x  (f_x),
        .f_u  (f_u),
        .deny (deny)
    );

    ptw_addr_gen #(
        .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .PTE_W(PTE_W)
    ) u_addr (
        .va       (va_q),
        .level    (lvl_q),
        .tbl_ppn  (ptr_q),
        .leaf_ppn (d_ppn),
        .rd_addr  (rd_addr),
        .leaf_pa  (leaf_pa),
        .misalign (misalign)
    );

    // Fault decision for the entry held in CHECK.
    assign chk_fault = !f_v || bad_enc
                    || (is_ptr && lvl_q == '0)
                    || (is_leaf && (misalign || deny));

    // Walk sequencing and capture of request, entry and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            va_q    <= '0;
            acc_q   <= '0;
            user_q  <= 1'b0;
            ptr_q   <= '0;
            lvl_q   <= '0;
            pte_q   <= '0;
            pa_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    va_q    <= req_vaddr;
                    acc_q   <= req_acc;
                    user_q  <= req_user;
                    ptr_q   <= root_ppn;
                    lvl_q   <= LVL_W'(LEVELS-1);
                    state_q <= ST_READ;
                end
                ST_READ: if (mem_req_ready) state_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    pte_q   <= mem_rsp_data;
                    state_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (chk_fault) begin
                        state_q <= ST_FAULT;
                    end else if (is_ptr) begin
                        ptr_q   <= d_ppn;
                        lvl_q   <= lvl_q - 1'b1;
                        state_q <= ST_READ;
                    end else begin
                        pa_q    <= leaf_pa;
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port outputs decoded from the registered state.
    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_READ);
    assign mem_req_addr  = rd_addr;
    assign done          = (state_q == ST_DONE) || (state_q == ST_FAULT);
    assign done_fault    = (state_q == ST_FAULT);
    assign done_paddr    = (state_q == ST_DONE) ? pa_q : '0;

endmodule

// File: rtl/ptw_walker_chk.sv
// Checker for the walker's port protocol, attached by bind. Tracks the read
// in flight and the reads per walk with its own counters.
module ptw_walker_chk #(
    parameter int LEVELS = 3,
    parameter int PA_W   = 56
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            done,
    input logic            done_fault,
    input logic [PA_W-1:0] done_paddr
);

    logic       pend_q;
    logic [3:0] rd_cnt_q;

    // Read in flight: set on accept, cleared on response.
    always_ff @(posedge clk) begin
        if (!rst_n)                             pend_q <= 1'b0;
        else if (mem_req_valid && mem_req_ready) pend_q <= 1'b1;
        else if (mem_rsp_valid)                  pend_q <= 1'b0;
    end

    // Reads accepted since the current walk began (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)                              rd_cnt_q <= '0;
        else if (req_valid && req_ready)         rd_cnt_q <= '0;
        else if (mem_req_valid && mem_req_ready && rd_cnt_q != 4'hF)
            rd_cnt_q <= rd_cnt_q + 4'd1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid && !done); // R1
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R2
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !mem_req_valid); // R2
    AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rd_cnt_q <= 4'(LEVELS)); // R2
    AST_NO_READ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req_valid && !pend_q); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_fault |-> done_paddr == '0); // R11
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R11

endmodule

bind ptw_walker ptw_walker_chk #(.LEVELS(LEVELS), .PA_W(PPN_W + OFF_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .done_fault    (done_fault),
    .done_paddr    (done_paddr)
);

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
// Directed bench for the page table walker: a behavioural memory holds the
// tables, one task per scenario drives a walk and checks its own results.
module ptw_walker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [38:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic [43:0] root_ppn = 44'h100;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [55:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done;
    logic        done_fault;
    logic [55:0] done_paddr;

    int vectors = 0;
    int miscompares = 0;
    int rd_total = 0;
    int stall_left = 0;
    int cycles = 0;
    logic [55:0] rd_log [64];
    logic [63:0] pmem [logic [55:0]];

    localparam logic [4:0] FV = 5'h01, FR = 5'h02, FW = 5'h04, FX = 5'h08, FU = 5'h10;

    ptw_walker u_ptw_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_user(req_user), .root_ppn(root_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .done_fault(done_fault),
        .done_paddr(done_paddr)
    );

    always #2.5 clk = ~clk;

    assign mem_req_ready = (stall_left == 0);

    // Behavioural memory: one-cycle response, optional ready stall.
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && stall_left > 0) stall_left <= stall_left - 1;
        if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= pmem.exists(mem_req_addr) ? pmem[mem_req_addr] : 64'h0;
            rd_log[rd_total % 64] = mem_req_addr;
            rd_total = rd_total + 1;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 100000) begin
            miscompares = miscompares + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic [4:0] fl);
        return {10'h0, ppn, 5'h0, fl};
    endfunction

    function automatic logic [55:0] ent_addr(input logic [43:0] ppn, input int idx);
        return {ppn, 12'h0} + 56'(idx * 8);
    endfunction

    function automatic logic [38:0] mk_va(input int v2, input int v1, input int v0, input int off);
        return {9'(v2), 9'(v1), 9'(v0), 12'(off)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors = vectors + 1;
        if (!ok) begin
            miscompares = miscompares + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One walk: drive, wait for done, check fault, address, read count, pulse.
    task automatic walk(input logic [38:0] va, input logic [1:0] acc, input logic user,
                        input bit exp_fault, input logic [55:0] exp_pa,
                        input int exp_reads, input string req, input bit noise);
        int start;
        bit seen;
        int reads;
        logic f;
        logic [55:0] pa;
        seen = 0;
        f = 1'b0;
        pa = '0;
        @(negedge clk);
        start = rd_total;
        req_valid = 1'b1;
        req_vaddr = va;
        req_acc   = acc;
        req_user  = user;
        @(negedge clk);
        if (noise) begin
            req_vaddr = ~va;
            req_acc   = 2'd3;
            req_user  = ~user;
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 0; i < 80; i++) begin
            if (done) begin
                seen = 1;
                f  = done_fault;
                pa = done_paddr;
                break;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(seen, req, "done seen", 64'(seen), 64'd1);
        reads = rd_total - start;
        check(f == exp_fault, req, "fault flag", 64'(f), 64'(exp_fault));
        check(pa == (exp_fault ? 56'h0 : exp_pa), req, "paddr", 64'(pa),
              64'(exp_fault ? 56'h0 : exp_pa));
        check(reads == exp_reads, req, "read count", 64'(reads), 64'(exp_reads));
        @(negedge clk);
        check(!done, "R11", "done one cycle", 64'(done), 64'd0);
    endtask

    task automatic t_reset;
        check(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
        check(!mem_req_valid, "R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
        check(!done && !done_fault, "R1", "done", 64'({done, done_fault}), 64'd0);
        check(done_paddr == '0, "R1", "done_paddr", 64'(done_paddr), 64'd0);
    endtask

    task automatic t_small_page;
        // R3: 4 KB leaf, three reads; R2: addresses of each read.
        walk(mk_va(1, 2, 3, 'h456), 2'd0, 1'b0, 0, {44'hABCDE, 12'h456}, 3, "R3", 0);
        check(rd_log[(rd_total-3) % 64] == ent_addr(44'h100, 1), "R2", "read 0 addr",
              64'(rd_log[(rd_total-3) % 64]), 64'(ent_addr(44'h100, 1)));
        check(rd_log[(rd_total-2) % 64] == ent_addr(44'h101, 2), "R2", "read 1 addr",
              64'(rd_log[(rd_total-2) % 64]), 64'(ent_addr(44'h101, 2)));
        check(rd_log[(rd_total-1) % 64] == ent_addr(44'h102, 3), "R2", "read 2 addr",
              64'(rd_log[(rd_total-1) % 64]), 64'(ent_addr(44'h102, 3)));
    endtask

    task automatic t_access_kinds;
        walk(mk_va(1, 2, 3, 'h008), 2'd1, 1'b0, 0, {44'hABCDE, 12'h008}, 3, "R9", 0);
        walk(mk_va(1, 2, 3, 'h008), 2'd2, 1'b0, 1, '0, 3, "R9", 0);
        walk(mk_va(1, 2, 3, 'h008), 2'd3, 1'b0, 1, '0, 3, "R9", 0);
    endtask

    task automatic t_user_mode;
        walk(mk_va(1, 2, 3, 'h0), 2'd0, 1'b1, 1, '0, 3, "R10", 0);
        walk(mk_va(1, 2, 6, 'h10), 2'd2, 1'b1, 0, {44'h12345, 12'h010}, 3, "R10", 0);
        walk(mk_va(1, 2, 6, 'h10), 2'd1, 1'b1, 1, '0, 3, "R10", 0);
        walk(mk_va(1, 2, 6, 'h20), 2'd0, 1'b0, 0, {44'h12345, 12'h020}, 3, "R10", 0);
    endtask

    task automatic t_invalid;
        walk(mk_va(5, 0, 0, 0), 2'd0, 1'b0, 1, '0, 1, "R4", 0);
        walk(mk_va(1, 11, 0, 0), 2'd0, 1'b0, 1, '0, 2, "R4", 0);
    endtask

    task automatic t_bad_encodings;
        walk(mk_va(1, 2, 4, 0), 2'd1, 1'b0, 1, '0, 3, "R5", 0);
        walk(mk_va(1, 2, 5, 0), 2'd0, 1'b0, 1, '0, 3, "R6", 0);
    endtask

    task automatic t_huge;
        walk(mk_va(1, 7, 'h1A5, 'h321), 2'd0, 1'b0, 0,
             {44'h40000 | 44'h1A5, 12'h321}, 2, "R7", 0);
        walk(mk_va(1, 7, 'h1A5, 'h321), 2'd1, 1'b0, 1, '0, 2, "R9", 0);
        walk(mk_va(9, 'h12, 'h34, 'hABC), 2'd2, 1'b0, 0,
             {44'h80000 | {26'h0, 9'h12, 9'h34}, 12'hABC}, 1, "R7", 0);
    endtask

    task automatic t_misaligned;
        walk(mk_va(1, 8, 0, 0), 2'd0, 1'b0, 1, '0, 2, "R8", 0);
        walk(mk_va(10, 0, 0, 0), 2'd0, 1'b0, 1, '0, 1, "R8", 0);
    endtask

    task automatic t_stall;
        stall_left = 5;
        walk(mk_va(1, 2, 3, 'h7FF), 2'd0, 1'b0, 0, {44'hABCDE, 12'h7FF}, 3, "R2", 0);
    endtask

    task automatic t_busy_ignore;
        walk(mk_va(9, 1, 2, 'h3), 2'd0, 1'b0, 0,
             {44'h80000 | {26'h0, 9'h1, 9'h2}, 12'h003}, 1, "R11", 1);
        walk(mk_va(1, 2, 3, 'h44), 2'd0, 1'b0, 0, {44'hABCDE, 12'h044}, 3, "R11", 1);
    endtask

    initial begin
        pmem[ent_addr(44'h100, 1)]  = mk_pte(44'h101, FV);
        pmem[ent_addr(44'h101, 2)]  = mk_pte(44'h102, FV);
        pmem[ent_addr(44'h102, 3)]  = mk_pte(44'hABCDE, FV | FR | FW);
        pmem[ent_addr(44'h102, 4)]  = mk_pte(44'h55555, FV | FW);
        pmem[ent_addr(44'h102, 5)]  = mk_pte(44'h103, FV);
        pmem[ent_addr(44'h102, 6)]  = mk_pte(44'h12345, FV | FR | FX | FU);
        pmem[ent_addr(44'h101, 7)]  = mk_pte(44'h40000, FV | FR);
        pmem[ent_addr(44'h101, 8)]  = mk_pte(44'h40001, FV | FR);
        pmem[ent_addr(44'h101, 11)] = mk_pte(44'h7, FR);
        pmem[ent_addr(44'h100, 9)]  = mk_pte(44'h80000, FV | FR | FW | FX);
        pmem[ent_addr(44'h100, 10)] = mk_pte(44'h80200, FV | FR);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_small_page();
        t_access_kinds();
        t_user_mode();
        t_invalid();
        t_bad_encodings();
        t_huge();
        t_misaligned();
        t_stall();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule